// File: doc/BRIEF.md
# Training Mailbox Handshake Receiver

This block reads messages posted by a memory-training microcontroller through a two-word mailbox. The sender signals that a message is waiting by pulling an active-low ready flag to 0 and presents a low and a high 16-bit data half. The receiver takes the data, lowers its acknowledge line, waits for the sender to release ready, and then raises acknowledge again. Each message costs one full four-phase handshake.

A session begins on a start pulse. Every message read outside a stream is a major message. Its code is taken from the low half only, and the block sorts it into one of four classes: progress, stream opening, pass or fail. A stream opening is followed by a header word. The low half of the header gives the number of argument words still to come. Header and argument words are full 32-bit words, with the high half above the low half. Each one is shown for one cycle on a valid output that also carries a header flag.

A pass or fail code ends the session. It raises a one-cycle done pulse and sets a status flag that stays set until the next start. The block then stays idle and does not answer the mailbox.

Top module: `train_mbox_rx`

## Requirements
- R1: After reset, ack_n is 1 and done, pass, fail, major_valid and word_valid are 0. Until start is pulsed, ack_n stays 1 even if rdy_n is 0.
- R2: In an active session the block waits while rdy_n is 1. The clock edge after rdy_n is seen at 0 captures the mailbox and drives ack_n to 0.
- R3: ack_n stays 0 for as long as rdy_n stays 0. The first edge that sees rdy_n at 1 returns ack_n to 1. Data is captured before the acknowledge, so changes to the mailbox during the acknowledge have no effect.
- R4: A major message uses only lo_word as its code; hi_word is ignored. major_valid pulses for one cycle, in the cycle where ack_n returns to 1, with major_class set to 0 for progress, 1 for stream, 2 for pass or 3 for fail.
- R5: Major code 0x0008 (class 1) makes the next message a header. The header is shown as word_data = {hi_word, lo_word} with word_valid = 1 and word_is_hdr = 1.
- R6: The header's low 16 bits give N. The next N messages are arguments, each shown as {hi_word, lo_word} with word_valid = 1 and word_is_hdr = 0. After the N-th argument, the next message is treated as a major message again.
- R7: A header with N = 0 ends the stream at once, so the next message is a major message.
- R8: Code 0x0007 sets pass and pulses done for one cycle. The block then goes idle and keeps ack_n at 1.
- R9: Code 0x00FF sets fail and pulses done for one cycle. Exactly one of pass and fail is 1 while done is high.
- R10: Any other code, including values such as 0x0107, is progress (class 0). The block keeps waiting for mail.
- R11: pass and fail hold their values until the next start, and start clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a session when idle |
| rdy_n | input | 1 | Sender ready flag, 0 = message waiting |
| lo_word | input | 16 | Low mailbox half |
| hi_word | input | 16 | High mailbox half |
| ack_n | output | 1 | Receiver acknowledge, 0 = taking message |
| major_valid | output | 1 | One-cycle strobe for a classified major message |
| major_class | output | 2 | 0 progress, 1 stream, 2 pass, 3 fail |
| word_valid | output | 1 | One-cycle strobe for a header or argument word |
| word_is_hdr | output | 1 | 1 when the shown word is a stream header |
| word_data | output | 32 | Captured stream word {hi, lo} |
| done | output | 1 | One-cycle end-of-training pulse |
| pass | output | 1 | Sticky training success |
| fail | output | 1 | Sticky training failure |

## Verification
A wrong message-kind state shows up at the next handshake as a wrong strobe. A major code might come out as a word, or an argument might carry the header flag. The count is the likeliest thing to drift, so random streams of zero to several arguments are each followed by a terminal code. An off-by-one count then turns pass into a word, or a word into a misclassified major message, within one message. A wrong handshake state shows within a cycle as ack_n falling late or rising while rdy_n is still 0. The random sender timing stretches both phases.

// File: rtl/train_mbox_rx.sv
module train_mbox_rx #(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] CODE_STREAM = 'h08,
  parameter logic [HALF_W-1:0] CODE_PASS = 'h07,
  parameter logic [HALF_W-1:0] CODE_FAIL = 'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                rdy_n,
  input  logic [HALF_W-1:0]   lo_word,
  input  logic [HALF_W-1:0]   hi_word,
  output logic                ack_n,
  output logic                major_valid,
  output logic [1:0]          major_class,
  output logic                word_valid,
  output logic                word_is_hdr,
  output logic [2*HALF_W-1:0] word_data,
  output logic                done,
  output logic                pass,
  output logic                fail
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [1:0] CL_PROG = 2'd0, CL_STREAM = 2'd1, CL_PASS = 2'd2, CL_FAIL = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} st_t;
  typedef enum logic [1:0] {K_MAJOR, K_HDR, K_ARG} kind_t;

  st_t              st;
  kind_t            kind;
  logic [WORD_W-1:0] cap;
  logic [HALF_W-1:0] remain;
  logic [1:0]        cls;

  // The major code is the low half, zero-extended, compared at full width.
  always_comb begin
    if (cap == {{HALF_W{1'b0}}, CODE_STREAM})    cls = CL_STREAM;
    else if (cap == {{HALF_W{1'b0}}, CODE_PASS}) cls = CL_PASS;
    else if (cap == {{HALF_W{1'b0}}, CODE_FAIL}) cls = CL_FAIL;
    else                                         cls = CL_PROG;
  end

  assign word_data = cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      kind        <= K_MAJOR;
      cap         <= '0;
      remain      <= '0;
      ack_n       <= 1'b1;
      major_valid <= 1'b0;
      major_class <= CL_PROG;
      word_valid  <= 1'b0;
      word_is_hdr <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
    end else begin
      major_valid <= 1'b0;
      word_valid  <= 1'b0;
      done        <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            pass <= 1'b0;
            fail <= 1'b0;
            kind <= K_MAJOR;
            st   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!rdy_n) begin
            cap   <= (kind == K_MAJOR) ? {{HALF_W{1'b0}}, lo_word} : {hi_word, lo_word};
            ack_n <= 1'b0;
            st    <= S_ACK;
          end
        end
        S_ACK: begin
          if (rdy_n) begin
            ack_n <= 1'b1;
            st    <= S_WAIT;
            case (kind)
              K_MAJOR: begin
                major_valid <= 1'b1;
                major_class <= cls;
                if (cls == CL_STREAM) kind <= K_HDR;
                if (cls == CL_PASS || cls == CL_FAIL) begin
                  pass <= (cls == CL_PASS);
                  fail <= (cls == CL_FAIL);
                  done <= 1'b1;
                  st   <= S_IDLE;
                end
              end
              K_HDR: begin
                word_valid  <= 1'b1;
                word_is_hdr <= 1'b1;
                remain      <= cap[HALF_W-1:0];
                kind        <= (cap[HALF_W-1:0] == '0) ? K_MAJOR : K_ARG;
              end
              default: begin
                word_valid  <= 1'b1;
                word_is_hdr <= 1'b0;
                remain      <= remain - 1'b1;
                if (remain == {{(HALF_W-1){1'b0}}, 1'b1}) kind <= K_MAJOR;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module train_mbox_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_n,
  input logic ack_n,
  input logic major_valid,
  input logic word_valid,
  input logic done,
  input logic pass,
  input logic fail
);
  p_ack_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!rdy_n));
  p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> $past(rdy_n));
  p_major_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    major_valid |-> $rose(ack_n));
  p_word_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ($rose(ack_n) && !major_valid));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pass ^ fail) && major_valid));
endmodule

bind train_mbox_rx train_mbox_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .ack_n(ack_n),
  .major_valid(major_valid), .word_valid(word_valid),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/train_mbox_rx_test.sv
`timescale 1ns/1ps
module train_mbox_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rdy_n = 1'b1;
  logic [15:0] lo = '0, hi = '0;
  logic ack_n, major_valid, word_valid, word_is_hdr, done, pass, fail;
  logic [1:0] major_class;
  logic [31:0] word_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic o_mv, o_wv, o_hdr, o_done, o_pass, o_fail;
  logic [1:0] o_cls;
  logic [31:0] o_word;

  train_mbox_rx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rdy_n(rdy_n),
    .lo_word(lo), .hi_word(hi), .ack_n(ack_n),
    .major_valid(major_valid), .major_class(major_class),
    .word_valid(word_valid), .word_is_hdr(word_is_hdr), .word_data(word_data),
    .done(done), .pass(pass), .fail(fail)
  );

  always #2.5 clk = ~clk;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_class(input logic [15:0] code);
    if (code == 16'h0008) return 2'd1;
    if (code == 16'h0007) return 2'd2;
    if (code == 16'h00FF) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [15:0] prog_code();
    logic [15:0] c;
    c = 16'($urandom);
    while (exp_class(c) != 2'd0) c = 16'($urandom);
    return c;
  endfunction

  // One four-phase handshake seen from the sender side.
  task automatic xfer(input logic [15:0] l, input logic [15:0] h);
    int pre, hold;
    pre = $urandom_range(0, 3);
    hold = $urandom_range(0, 4);
    repeat (pre) @(negedge clk);
    lo = l; hi = h; rdy_n = 1'b0;
    @(negedge clk);
    check_eq("R2 ack_n falls one edge after ready", ack_n, 0);
    repeat (hold) begin
      @(negedge clk);
      check_eq("R3 ack_n held while ready low", ack_n, 0);
    end
    rdy_n = 1'b1; lo = 16'($urandom); hi = 16'($urandom);
    @(negedge clk);
    check_eq("R3 ack_n released after ready high", ack_n, 1);
    o_mv = major_valid; o_cls = major_class; o_wv = word_valid; o_hdr = word_is_hdr;
    o_word = word_data; o_done = done; o_pass = pass; o_fail = fail;
  endtask

  task automatic major(input logic [15:0] code, input logic [15:0] h);
    logic [1:0] c;
    bit term;
    c = exp_class(code);
    term = (c >= 2'd2);
    xfer(code, h);
    check_eq("R4 major_valid", o_mv, 1);
    check_eq("R4 major_class (R10 progress)", o_cls, c);
    check_eq("R4 no word strobe on major", o_wv, 0);
    check_eq("R8 R9 done only on terminal code", o_done, term);
    if (term) begin
      check_eq("R8 pass flag", o_pass, c == 2'd2);
      check_eq("R9 fail flag", o_fail, c == 2'd3);
    end
  endtask

  task automatic stream_word(input logic [15:0] l, input logic [15:0] h, input bit hdr);
    xfer(l, h);
    check_eq("R5 R6 word_valid", o_wv, 1);
    check_eq("R5 R6 word_is_hdr", o_hdr, hdr);
    check_eq("R5 R6 word_data", o_word, {h, l});
    check_eq("R6 no major strobe on word", o_mv, 0);
  endtask

  task automatic session(input int nprog, input int nargs, input bit ok);
    logic p_before;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_eq("R11 start clears pass", pass, 0);
    check_eq("R11 start clears fail", fail, 0);
    for (int i = 0; i < nprog; i++) major(prog_code(), 16'($urandom));
    if (nargs >= 0) begin
      major(16'h0008, 16'($urandom));
      stream_word(16'(nargs), 16'($urandom), 1'b1);   // R7 when nargs is zero
      for (int i = 0; i < nargs; i++) stream_word(16'($urandom), 16'($urandom), 1'b0);
      if ($urandom_range(0, 1) == 1) major(prog_code(), 16'($urandom));
    end
    major(ok ? 16'h0007 : 16'h00FF, 16'($urandom));
    p_before = pass;
    rdy_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_eq("R8 idle keeps ack_n high", ack_n, 1);
      check_eq("R11 pass sticky", pass, p_before);
      check_eq("R8 done is one cycle", done, 0);
    end
    rdy_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_eq("R1 reset ack_n", ack_n, 1);
    rst_n = 1'b1;
    rdy_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 ack_n idle before start", ack_n, 1);
    check_eq("R1 done", done, 0);
    check_eq("R1 pass", pass, 0);
    check_eq("R1 fail", fail, 0);
    check_eq("R1 strobes", {major_valid, word_valid}, 0);
    rdy_n = 1'b1;
    @(negedge clk);
    // Directed: high half ignored for major code, 0x0107 is progress (R4, R10)
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    major(16'h0107, 16'h0000);
    major(16'h0008, 16'hFFFF);
    stream_word(16'h0000, 16'hABCD, 1'b1);          // R7 zero count
    major(16'h0007, 16'hFFFF);                      // R8 pass despite high half
    session(1, 3, 1'b0);                            // R9 fail after a stream
    session(0, 1, 1'b1);
    for (int s = 0; s < 20; s++)
      session($urandom_range(0, 3), $urandom_range(0, 5) - 1, $urandom_range(0, 1) == 1);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule